// File: doc/BRIEF.md
# Dual Four-Mode Timer/Counter

This block holds two programmable up-counters. Each has a low count byte, a high count byte, a run bit and a sticky overflow flag. A shared configuration byte gives each unit a 2-bit mode and a source select. With the source select clear, a unit advances on the machine-cycle strobe `tickEn`, which the surrounding logic raises once every 12 oscillator clocks. With the source select set, a unit advances on falling edges of its external count pin.

The four modes are:
- a 13-bit counter made from the whole high byte and a 5-bit prescaler in the low byte;
- a plain 16-bit counter;
- an 8-bit low-byte counter that reloads from the high byte on each wrap;
- a split mode, valid for unit 0 only, in which unit 0's two bytes count as independent 8-bit counters. The high half borrows unit 1's run bit and flag.

Software reaches the count bytes and the two control bytes through a simple write strobe and a combinational read port. The two flags are the only outputs to the rest of the chip. Each flag has its own clear input.

Top module: `dual_tc_core`

## Requirements
- R1: After reset, all four count bytes, the configuration byte (address 4) and the run/flag byte (address 5) read 0, and both flag outputs are low.
- R2: Mode 00 (13-bit) uses `{high, low[4:0]}` as the count. A step from low[4:0]=1Fh carries into the high byte. A step from 1FFFh gives 0000h and sets the flag. Low-byte bits 7:5 read zero after any step and after any write made in this mode.
- R3: Mode 01 (16-bit) steps `{high, low}` by exactly one per event. FFFFh rolls to 0000h and sets the flag.
- R4: Mode 10 (reload) steps only the low byte. On the step from FFh, the low byte takes the high byte's value in the same clock and the flag sets.
- R5: Mode 11 on unit 0 (split) runs the low byte as an 8-bit counter on unit 0's run bit, source and flag. The high byte runs as an 8-bit counter of `tickEn` only, on unit 1's run bit and flag.
- R6: While unit 0 is split, unit 1 in modes 00/01/10 counts regardless of its run bit and never sets its flag. Unit 1 in mode 11 holds its count.
- R7: A unit steps only on an event while its run bit is set. With the run bit clear, or with no event, the count holds.
- R8: In counter mode the pin passes through two synchronising flops. It counts once when a `tickEn` sample sees it low after the previous `tickEn` sample saw it high, so at most one count is taken per machine cycle.
- R9: A write to a count byte in the same clock as a step wins: the byte takes the written value. The unit's step is dropped; in split mode only the written half's step is dropped.
- R10: Flags stay set until `clrOvfN` is pulsed or address 5 is written, where bit 4 loads flag 0 and bit 5 loads flag 1. An overflow in the same clock as a clear leaves the flag set.
- R11: Addresses: 0 low0, 1 high0, 2 low1, 3 high1, 4 configuration (bits 1:0 unit 0 mode, bit 2 unit 0 source, bits 5:4 unit 1 mode, bit 6 unit 1 source), 5 run/flag (bit 0 run0, bit 1 run1, bits 5:4 flags). Configuration reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Machine-cycle strobe |
| extIn0 | input | 1 | External count pin, unit 0 |
| extIn1 | input | 1 | External count pin, unit 1 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data, combinational |
| clrOvf0 | input | 1 | Clear pulse for flag 0 |
| clrOvf1 | input | 1 | Clear pulse for flag 1 |
| ovf0 | output | 1 | Overflow flag, unit 0 |
| ovf1 | output | 1 | Overflow flag, unit 1 / split high half |

## Verification
A register write, a `tickEn` step and a flag change all appear after the next rising edge. The bench drives each stimulus for one cycle starting at a falling edge, then samples counts and flags at the following falling edge.

External pin edges take two clocks to cross the synchroniser, and are then counted only at a `tickEn` sample. The bench therefore holds each pin level across several ticks, so the expected count does not depend on which tick first sees the edge. Reads are combinational, so they are taken a short delay after the address is set, away from any edge.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned PRESCALE_W  = 5;
  localparam int unsigned ADDR_W      = 3;
  localparam int unsigned UNITS       = 2;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned CNT13_W     = BYTE_W + PRESCALE_W;

  localparam logic [ADDR_W-1:0] ADDR_LO0  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_HI0  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LO1  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_HI1  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_RUN  = 3'd5;

  typedef enum logic [1:0] {
    MODE_13     = 2'b00,
    MODE_16     = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tcMode_e;

  typedef struct packed {
    logic [UNITS-1:0] wrLo;
    logic [UNITS-1:0] wrHi;
    logic [UNITS-1:0] stepLo;
    logic             stepHiSplit;
    tcMode_e          mode0;
    tcMode_e          mode1;
  } tcStrobe_t;
endpackage

// File: rtl/dtc_ctrl.sv
module dtc_ctrl
  import dtc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     tickEn,
  input  logic [UNITS-1:0]         extIn,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [BYTE_W-1:0]        wrData,
  input  logic [UNITS-1:0]         clrOvf,
  input  logic [UNITS-1:0]         wrapLo,
  input  logic                     wrapHiSplit,
  output tcStrobe_t                strb,
  output logic [BYTE_W-1:0]        modeCfg,
  output logic [BYTE_W-1:0]        runStat,
  output logic [UNITS-1:0]         ovf
);
  logic [UNITS-1:0] runQ;
  logic [UNITS-1:0] ovfQ;
  logic [UNITS-1:0] extSel;
  logic [UNITS-1:0] extEvt;
  logic [UNITS-1:0] srcEvt;
  logic [UNITS-1:0] anyWr;
  logic [UNITS-1:0] setFlag;
  logic             splitOn;
  logic             wrCfg;
  logic             wrRun;

  assign wrCfg   = wrEn && (wrAddr == ADDR_CFG);
  assign wrRun   = wrEn && (wrAddr == ADDR_RUN);
  assign extSel  = {modeCfg[6], modeCfg[2]};
  assign splitOn = (strb.mode0 == MODE_SPLIT);

  assign strb.mode0 = tcMode_e'(modeCfg[1:0]);
  assign strb.mode1 = tcMode_e'(modeCfg[5:4]);

  // Per-unit pin synchroniser, tick-sampled edge detect and write decode
  for (genvar u = 0; u < UNITS; u++) begin : g_src
    logic [SYNC_STAGES-1:0] syncChain;
    logic                   lastLvl;
    logic                   syncLvl;

    assign syncLvl = syncChain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        syncChain <= '0;
        lastLvl   <= 1'b0;
      end else begin
        syncChain <= {syncChain[SYNC_STAGES-2:0], extIn[u]};
        if (tickEn) lastLvl <= syncLvl;
      end
    end

    assign extEvt[u]    = tickEn && lastLvl && !syncLvl;
    assign srcEvt[u]    = extSel[u] ? extEvt[u] : tickEn;
    assign strb.wrLo[u] = wrEn && (wrAddr == ADDR_W'(2 * u));
    assign strb.wrHi[u] = wrEn && (wrAddr == ADDR_W'(2 * u + 1));
    assign anyWr[u]     = strb.wrLo[u] || strb.wrHi[u];
  end

  // Step gating: run bits, split borrowing, write priority
  assign strb.stepLo[0]  = runQ[0] && srcEvt[0] &&
                           (splitOn ? !strb.wrLo[0] : !anyWr[0]);
  assign strb.stepHiSplit = splitOn && runQ[1] && tickEn && !strb.wrHi[0];
  assign strb.stepLo[1]  = (strb.mode1 != MODE_SPLIT) && srcEvt[1] &&
                           !anyWr[1] && (splitOn || runQ[1]);

  assign setFlag[0] = wrapLo[0];
  assign setFlag[1] = splitOn ? wrapHiSplit : wrapLo[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeCfg <= '0;
      runQ    <= '0;
    end else begin
      if (wrCfg) modeCfg <= wrData;
      if (wrRun) runQ    <= wrData[1:0];
    end
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN)            ovfQ[u] <= 1'b0;
      else if (setFlag[u])  ovfQ[u] <= 1'b1;
      else if (wrRun)       ovfQ[u] <= wrData[4 + u];
      else if (clrOvf[u])   ovfQ[u] <= 1'b0;
    end
  end

  assign ovf     = ovfQ;
  assign runStat = {2'b00, ovfQ, 2'b00, runQ};
endmodule

// File: rtl/dtc_datapath.sv
module dtc_datapath
  import dtc_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  tcStrobe_t                     strb,
  input  logic [BYTE_W-1:0]             wrData,
  output logic [UNITS-1:0][BYTE_W-1:0]  loByte,
  output logic [UNITS-1:0][BYTE_W-1:0]  hiByte,
  output logic [UNITS-1:0]              wrapLo,
  output logic                          wrapHiSplit
);
  logic [UNITS-1:0] wrapHiV;

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    tcMode_e                 unitMode;
    logic [BYTE_W-1:0]       loQ, hiQ, loD, hiD;
    logic [CNT13_W-1:0]      sum13;
    logic [2*BYTE_W-1:0]     sum16;
    logic                    wrapL, wrapH, hiStep;

    assign unitMode = (u == 0) ? strb.mode0 : strb.mode1;
    assign hiStep   = (u == 0) && (unitMode == MODE_SPLIT) && strb.stepHiSplit;
    assign sum13    = {hiQ, loQ[PRESCALE_W-1:0]} + CNT13_W'(1);
    assign sum16    = {hiQ, loQ} + (2*BYTE_W)'(1);

    always_comb begin
      loD   = loQ;
      hiD   = hiQ;
      wrapL = 1'b0;
      wrapH = 1'b0;
      if (strb.stepLo[u]) begin
        unique case (unitMode)
          MODE_13: begin
            wrapL = &{hiQ, loQ[PRESCALE_W-1:0]};
            hiD   = sum13[CNT13_W-1:PRESCALE_W];
            loD   = BYTE_W'(sum13[PRESCALE_W-1:0]);
          end
          MODE_16: begin
            wrapL      = &{hiQ, loQ};
            {hiD, loD} = sum16;
          end
          MODE_RELOAD: begin
            if (&loQ) begin
              wrapL = 1'b1;
              loD   = hiQ;
            end else begin
              loD = loQ + BYTE_W'(1);
            end
          end
          MODE_SPLIT: begin
            if (u == 0) begin
              wrapL = &loQ;
              loD   = loQ + BYTE_W'(1);
            end
          end
        endcase
      end
      if (hiStep) begin
        wrapH = &hiQ;
        hiD   = hiQ + BYTE_W'(1);
      end
      if (strb.wrLo[u])
        loD = (unitMode == MODE_13) ? BYTE_W'(wrData[PRESCALE_W-1:0]) : wrData;
      if (strb.wrHi[u])
        hiD = wrData;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loQ <= '0;
        hiQ <= '0;
      end else begin
        loQ <= loD;
        hiQ <= hiD;
      end
    end

    assign loByte[u]  = loQ;
    assign hiByte[u]  = hiQ;
    assign wrapLo[u]  = wrapL;
    assign wrapHiV[u] = wrapH;
  end

  assign wrapHiSplit = |wrapHiV;
endmodule

// File: rtl/dual_tc_core.sv
module dual_tc_core
  import dtc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tickEn,
  input  logic        extIn0,
  input  logic        extIn1,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [7:0]  wrData,
  input  logic [2:0]  rdAddr,
  output logic [7:0]  rdData,
  input  logic        clrOvf0,
  input  logic        clrOvf1,
  output logic        ovf0,
  output logic        ovf1
);
  tcStrobe_t                     strb;
  logic [UNITS-1:0][BYTE_W-1:0]  loByte;
  logic [UNITS-1:0][BYTE_W-1:0]  hiByte;
  logic [UNITS-1:0]              wrapLo;
  logic                          wrapHiSplit;
  logic [BYTE_W-1:0]             modeCfg;
  logic [BYTE_W-1:0]             runStat;
  logic [UNITS-1:0]              ovfV;

  dtc_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .tickEn      (tickEn),
    .extIn       ({extIn1, extIn0}),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrData      (wrData),
    .clrOvf      ({clrOvf1, clrOvf0}),
    .wrapLo      (wrapLo),
    .wrapHiSplit (wrapHiSplit),
    .strb        (strb),
    .modeCfg     (modeCfg),
    .runStat     (runStat),
    .ovf         (ovfV)
  );

  dtc_datapath dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .loByte      (loByte),
    .hiByte      (hiByte),
    .wrapLo      (wrapLo),
    .wrapHiSplit (wrapHiSplit)
  );

  always_comb begin
    unique case (rdAddr)
      ADDR_LO0: rdData = loByte[0];
      ADDR_HI0: rdData = hiByte[0];
      ADDR_LO1: rdData = loByte[1];
      ADDR_HI1: rdData = hiByte[1];
      ADDR_CFG: rdData = modeCfg;
      ADDR_RUN: rdData = runStat;
      default:  rdData = '0;
    endcase
  end

  assign ovf0 = ovfV[0];
  assign ovf1 = ovfV[1];
endmodule

// File: rtl/dtc_checker.sv
module dtc_checker
  import dtc_pkg::*;
(
  input logic                         clk,
  input logic                         rstN,
  input logic                         tickEn,
  input logic                         wrEn,
  input logic [ADDR_W-1:0]            wrAddr,
  input logic [BYTE_W-1:0]            wrData,
  input logic                         clrOvf0,
  input logic                         clrOvf1,
  input logic                         ovf0,
  input logic                         ovf1,
  input logic [UNITS-1:0][BYTE_W-1:0] loByte,
  input logic [UNITS-1:0][BYTE_W-1:0] hiByte,
  input logic [BYTE_W-1:0]            modeCfg
);
  a_r10_flag0_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovf0 && !clrOvf0 && !(wrEn && wrAddr == ADDR_RUN)) |=> ovf0);

  a_r10_flag1_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovf1 && !clrOvf1 && !(wrEn && wrAddr == ADDR_RUN)) |=> ovf1);

  a_r7_flag_needs_event: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovf0) |-> $past(tickEn || (wrEn && wrAddr == ADDR_RUN)));

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !wrEn) |=> ($stable(loByte) && $stable(hiByte)));

  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_LO0 && modeCfg[1:0] != 2'b00)
      |=> (loByte[0] == $past(wrData)));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    (modeCfg[1:0] == 2'b01 && !wrEn)
      |=> (loByte[0] == $past(loByte[0]) || loByte[0] == $past(loByte[0]) + 8'd1));
endmodule

bind dual_tc_core dtc_checker chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .tickEn  (tickEn),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .clrOvf0 (clrOvf0),
  .clrOvf1 (clrOvf1),
  .ovf0    (ovf0),
  .ovf1    (ovf1),
  .loByte  (loByte),
  .hiByte  (hiByte),
  .modeCfg (modeCfg)
);

// File: tb/dual_tc_core_tb.sv
module dual_tc_core_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       extIn0 = 1'b0;
  logic       extIn1 = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       clrOvf0 = 1'b0;
  logic       clrOvf1 = 1'b0;
  logic       ovf0, ovf1;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  dual_tc_core dut_i (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .extIn0(extIn0), .extIn1(extIn1),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .clrOvf0(clrOvf0), .clrOvf1(clrOvf1),
    .ovf0(ovf0), .ovf1(ovf1)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic wrRegTick(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d; tickEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  // Reference: returns {flag, high, low} after n steps in mode md
  function automatic logic [16:0] refCount(input logic [1:0] md, input logic [7:0] lo,
                                           input logic [7:0] hi, input int n);
    logic        f = 1'b0;
    logic [12:0] v13;
    logic [15:0] v16;
    for (int i = 0; i < n; i++) begin
      case (md)
        2'b00: begin
          v13 = {hi, lo[4:0]};
          if (v13 == 13'h1FFF) f = 1'b1;
          v13 = v13 + 13'd1;
          hi = v13[12:5]; lo = {3'b000, v13[4:0]};
        end
        2'b01: begin
          v16 = {hi, lo};
          if (v16 == 16'hFFFF) f = 1'b1;
          v16 = v16 + 16'd1;
          {hi, lo} = v16;
        end
        default: begin
          if (lo == 8'hFF) begin f = 1'b1; lo = hi; end
          else lo = lo + 8'd1;
        end
      endcase
    end
    return {f, hi, lo};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] d2;
    logic [16:0] e;
    int unsigned seed;
    seed = $urandom(32'd20240611);

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rdReg(3'(a), d);
      chk("R1 reset register", 16'(d), 16'h0);
    end
    chk("R1 reset flags", {14'b0, ovf1, ovf0}, 16'h0);

    // R11 register map readback
    wrReg(3'd4, 8'h56);
    rdReg(3'd4, d); chk("R11 cfg readback", 16'(d), 16'h56);
    wrReg(3'd5, 8'h33);
    rdReg(3'd5, d); chk("R11 run/flag readback", 16'(d), 16'h33);
    chk("R10 flags loaded by write", {14'b0, ovf1, ovf0}, 16'h3);
    wrReg(3'd5, 8'h00);
    chk("R10 flags cleared by write", {14'b0, ovf1, ovf0}, 16'h0);

    // R2 13-bit mode
    wrReg(3'd4, 8'h00);
    wrReg(3'd5, 8'h01);
    wrReg(3'd0, 8'hFF);
    rdReg(3'd0, d); chk("R2 low write masked", 16'(d), 16'h1F);
    wrReg(3'd1, 8'h00);
    ticks(1);
    rdReg(3'd0, d); rdReg(3'd1, d2);
    chk("R2 prescale carry", {d2, d}, 16'h0100);
    wrReg(3'd1, 8'hFF); wrReg(3'd0, 8'h1E);
    ticks(1);
    chk("R2 no flag before wrap", {15'b0, ovf0}, 16'h0);
    ticks(1);
    rdReg(3'd0, d); rdReg(3'd1, d2);
    chk("R2 wrap to zero", {d2, d}, 16'h0000);
    chk("R2 flag on wrap", {15'b0, ovf0}, 16'h1);

    // R10 sticky and clear input, set beats clear
    ticks(3);
    chk("R10 flag sticky", {15'b0, ovf0}, 16'h1);
    @(negedge clk); clrOvf0 = 1'b1; @(negedge clk); clrOvf0 = 1'b0;
    chk("R10 clear input", {15'b0, ovf0}, 16'h0);
    wrReg(3'd4, 8'h01); wrReg(3'd0, 8'hFF); wrReg(3'd1, 8'hFF);
    @(negedge clk); tickEn = 1'b1; clrOvf0 = 1'b1;
    @(negedge clk); tickEn = 1'b0; clrOvf0 = 1'b0;
    chk("R10 set wins over clear", {15'b0, ovf0}, 16'h1);
    rdReg(3'd0, d); rdReg(3'd1, d2);
    chk("R3 16-bit rollover", {d2, d}, 16'h0000);

    // R7 run bit gating
    wrReg(3'd5, 8'h00); wrReg(3'd0, 8'h10); wrReg(3'd1, 8'h00);
    ticks(3);
    rdReg(3'd0, d); chk("R7 halted holds", 16'(d), 16'h10);
    wrReg(3'd5, 8'h01);
    repeat (5) @(negedge clk);
    rdReg(3'd0, d); chk("R7 no tick holds", 16'(d), 16'h10);
    ticks(3);
    rdReg(3'd0, d); chk("R7 running counts", 16'(d), 16'h13);

    // R9 write beats simultaneous step
    wrRegTick(3'd0, 8'h40);
    rdReg(3'd0, d); chk("R9 write wins low", 16'(d), 16'h40);
    wrRegTick(3'd1, 8'h22);
    rdReg(3'd0, d); rdReg(3'd1, d2);
    chk("R9 write to high drops step", {d2, d}, 16'h2240);

    // R4 auto-reload
    wrReg(3'd4, 8'h02); wrReg(3'd5, 8'h01);
    wrReg(3'd1, 8'hC0); wrReg(3'd0, 8'hFE);
    ticks(1);
    chk("R4 no flag at FF", {15'b0, ovf0}, 16'h0);
    ticks(1);
    rdReg(3'd0, d); chk("R4 reload from high", 16'(d), 16'hC0);
    chk("R4 flag on reload", {15'b0, ovf0}, 16'h1);

    // R5 split mode
    wrReg(3'd4, 8'h03); wrReg(3'd5, 8'h03);
    wrReg(3'd0, 8'hFF); wrReg(3'd1, 8'hFE);
    wrReg(3'd2, 8'h00); wrReg(3'd3, 8'h00);
    ticks(2);
    rdReg(3'd0, d);  chk("R5 split low", 16'(d), 16'h01);
    rdReg(3'd1, d2); chk("R5 split high", 16'(d2), 16'h00);
    chk("R5 split flags", {14'b0, ovf1, ovf0}, 16'h3);
    rdReg(3'd2, d);  chk("R6 unit1 counts in split", 16'(d), 16'h02);

    // R6 unit1 ignores run bit, cannot flag; split high needs run1
    wrReg(3'd5, 8'h01); wrReg(3'd4, 8'h23);
    wrReg(3'd3, 8'h10); wrReg(3'd2, 8'hFF); wrReg(3'd1, 8'h33);
    ticks(1);
    rdReg(3'd2, d);  chk("R6 unit1 reload without run", 16'(d), 16'h10);
    chk("R6 unit1 flag suppressed", {15'b0, ovf1}, 16'h0);
    rdReg(3'd1, d2); chk("R5 split high needs run1", 16'(d2), 16'h33);
    wrReg(3'd4, 8'h31); wrReg(3'd5, 8'h03); wrReg(3'd2, 8'h55);
    ticks(3);
    rdReg(3'd2, d);  chk("R6 unit1 mode 3 holds", 16'(d), 16'h55);

    // R8 external counting
    wrReg(3'd4, 8'h05); wrReg(3'd5, 8'h01);
    wrReg(3'd0, 8'h00); wrReg(3'd1, 8'h00);
    extIn0 = 1'b1; ticks(4);
    rdReg(3'd0, d); chk("R8 rising edge no count", 16'(d), 16'h00);
    extIn0 = 1'b0; ticks(4);
    rdReg(3'd0, d); chk("R8 one count per fall", 16'(d), 16'h01);
    for (int k = 0; k < 3; k++) begin
      extIn0 = 1'b1; ticks(3);
      extIn0 = 1'b0; ticks(3);
    end
    rdReg(3'd0, d); chk("R8 counts falls", 16'(d), 16'h04);
    extIn0 = 1'b1; repeat (6) @(negedge clk);
    extIn0 = 1'b0; repeat (6) @(negedge clk);
    rdReg(3'd0, d); chk("R8 no tick no count", 16'(d), 16'h04);
    ticks(2);
    rdReg(3'd0, d); chk("R8 pin edges without tick sample", 16'(d), 16'h04);

    // Random: modes 00/01/10 on unit 0 against the reference
    for (int it = 0; it < 30; it++) begin
      logic [1:0] md;
      logic [7:0] lo0, hi0;
      int n;
      md  = 2'($urandom % 3);
      lo0 = 8'($urandom);
      hi0 = 8'($urandom);
      n   = 1 + int'($urandom % 300);
      if (it % 5 == 0) begin lo0 = 8'hF0; hi0 = 8'hFF; end
      wrReg(3'd4, {6'b0, md});
      wrReg(3'd5, 8'h01);
      wrReg(3'd0, lo0); wrReg(3'd1, hi0);
      if (md == 2'b00) lo0 = {3'b000, lo0[4:0]};
      ticks(n);
      e = refCount(md, lo0, hi0, n);
      rdReg(3'd0, d); rdReg(3'd1, d2);
      if (md == 2'b00) chk("R2 random 13-bit count", {d2, d}, e[15:0]);
      else if (md == 2'b01) chk("R3 random 16-bit count", {d2, d}, e[15:0]);
      else chk("R4 random reload count", {d2, d}, e[15:0]);
      chk("R7 random flag", {15'b0, ovf0}, {15'b0, e[16]});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule